// File: doc/BRIEF.md
# Periodic Interrupt Timer with Watchdog

This block divides the bus clock with one free-running binary counter and uses it for two purposes. Software picks one of four taps on that counter. Each time the selected stage wraps, a sticky interrupt flag is set. The flag drives an interrupt request when the enable bit is set, and software clears it by writing a one to a clear bit.

The same tap pulse also drives a three-bit watchdog counter. If the watchdog is enabled and software does not strobe the watchdog clear in time, the counter overflows and the block raises a one-cycle reset request. At that point the divider and the watchdog counter restart from zero.

A watchdog clear resets only the three watchdog stages. The periodic divider keeps running, so the time from a clear to the timeout lies between seven and eight interrupt periods. Because the watchdog counts tap pulses, changing the rate select also changes the watchdog timeout.

Top module: `rti_wdog_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 5'b00011 (rate select 2'b11, enable 0, clear bit 0, flag 0). `irq` and `wd_rst_req` are low.
- R2: The rate select is written from `cfg_wdata[1:0]` and read on `cfg_rdata[1:0]`. It gives an interrupt period P = 2^(BASE_W+sel) bus cycles. The flag first rises P clock edges after reset release, then every P edges from the previous wrap.
- R3: The flag (`cfg_rdata[4]`) stays set until a write with `cfg_wdata[3]`=1. A write with `cfg_wdata[3]`=0 leaves it unchanged.
- R4: The clear bit position `cfg_rdata[3]` always reads 0.
- R5: `irq` is high exactly when the flag is set and the enable bit (`cfg_wdata[2]`, read on `cfg_rdata[2]`) is 1.
- R6: If a flag-clear write and a tap wrap fall on the same edge, the flag ends up set.
- R7: With `wd_enable` high and no watchdog clear, `wd_rst_req` pulses high for exactly one cycle, 8·P edges after reset release. The flag is set on that same edge.
- R8: A `wd_clear` strobe resets only the watchdog stages. The timeout then follows the clear by more than 7·P and at most 8·P edges, and is exactly 8·P when the clear falls on a wrap edge. Clearing every 100 edges at P=16 prevents any request.
- R9: With `wd_enable` low, `wd_rst_req` never rises.
- R10: The watchdog timeout scales with the rate select: 8·P for the selected P.
- R11: After a reset request, the divider restarts, so the next flag wrap comes P edges after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 4 | Write data: [1:0] rate select, [2] interrupt enable, [3] flag clear |
| cfg_rdata | output | 5 | Read data: [1:0] rate select, [2] enable, [3] always 0, [4] flag |
| wd_enable | input | 1 | Watchdog enable; low holds the watchdog stages at zero |
| wd_clear | input | 1 | Watchdog service strobe |
| irq | output | 1 | Interrupt request |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
Two pairs of events can land on the same edge. A software flag-clear write can coincide with a tap wrap that sets the flag, and a watchdog clear can coincide with the tap pulse that would advance the watchdog. The bench counts edges from reset release, so it can place the write strobe exactly on the wrap edge and expect the flag to remain set. It also places the watchdog clear once on a wrap edge and once on the edge after, and checks that the request arrives at the computed edge each time: 8·P after the clear in the first case and 8·P−1 in the second.

// File: rtl/rti_wdog_pkg.sv
package rti_wdog_pkg;
  localparam int unsigned NUM_RATES = 4;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned WD_STAGES = 3;
  localparam int unsigned WR_W      = 4;
  localparam int unsigned RD_W      = 5;

  // field positions shared by the write and read words
  localparam int unsigned F_RATE_LO = 0;
  localparam int unsigned F_RATE_HI = 1;
  localparam int unsigned F_IE      = 2;
  localparam int unsigned F_CLR     = 3;
  localparam int unsigned F_FLAG    = 4;

  typedef logic [SEL_W-1:0] rate_sel_t;

  localparam rate_sel_t RATE_AT_RESET = 2'b11;
endpackage

// File: rtl/rti_divider.sv
module rti_divider
  import rti_wdog_pkg::*;
#(
  parameter int unsigned BASE_W = 14
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  rate_sel_t sel,
  output logic      tick
);
  localparam int unsigned CNT_W = BASE_W + NUM_RATES - 1;

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     cnt_d;
  logic [NUM_RATES-1:0] tap_wrap;

  // one wrap detector per selectable tap: low stages all ones
  generate
    for (genvar s = 0; s < NUM_RATES; s++) begin : g_tap
      assign tap_wrap[s] = &cnt_q[BASE_W-1+s:0];
    end
  endgenerate

  assign tick = tap_wrap[sel];

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rti_wdog_chain.sv
module rti_wdog_chain
  import rti_wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clear,
  input  logic tick,
  output logic overflow,
  output logic req
);
  localparam logic [WD_STAGES-1:0] WD_LAST = '1;

  logic [WD_STAGES-1:0] wd_q;
  logic [WD_STAGES-1:0] wd_d;
  logic                 req_q;
  logic                 req_d;

  // a clear on the same edge as a tap pulse wins
  assign overflow = enable & ~clear & tick & (wd_q == WD_LAST);

  always_comb begin
    wd_d  = wd_q;
    req_d = overflow;
    if (!enable || clear) wd_d = '0;
    else if (tick)        wd_d = wd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= '0;
      req_q <= 1'b0;
    end else begin
      wd_q  <= wd_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/rti_ctrl_regs.sv
module rti_ctrl_regs
  import rti_wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [WR_W-1:0] cfg_wdata,
  input  logic            tick,
  output rate_sel_t       rate,
  output logic            ie,
  output logic            flag
);
  rate_sel_t rate_q, rate_d;
  logic      ie_q, ie_d;
  logic      flag_q, flag_d;
  logic      clr_req;

  assign clr_req = cfg_wr & cfg_wdata[F_CLR];

  always_comb begin
    rate_d = rate_q;
    ie_d   = ie_q;
    if (cfg_wr) begin
      rate_d = cfg_wdata[F_RATE_HI:F_RATE_LO];
      ie_d   = cfg_wdata[F_IE];
    end
    // a new wrap takes priority over a software clear
    if (tick)         flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_AT_RESET;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rate_q <= rate_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  assign rate = rate_q;
  assign ie   = ie_q;
  assign flag = flag_q;
endmodule

// File: rtl/rti_wdog_timer.sv
module rti_wdog_timer
  import rti_wdog_pkg::*;
#(
  parameter int unsigned BASE_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [WR_W-1:0] cfg_wdata,
  output logic [RD_W-1:0] cfg_rdata,
  input  logic            wd_enable,
  input  logic            wd_clear,
  output logic            irq,
  output logic            wd_rst_req
);
  rate_sel_t rate;
  logic      ie;
  logic      flag;
  logic      tick;
  logic      wd_over;

  rti_divider #(.BASE_W(BASE_W)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wd_over),
    .sel     (rate),
    .tick    (tick)
  );

  rti_wdog_chain wdg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (wd_enable),
    .clear    (wd_clear),
    .tick     (tick),
    .overflow (wd_over),
    .req      (wd_rst_req)
  );

  rti_ctrl_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .tick      (tick),
    .rate      (rate),
    .ie        (ie),
    .flag      (flag)
  );

  always_comb begin
    cfg_rdata                      = '0;
    cfg_rdata[F_RATE_HI:F_RATE_LO] = rate;
    cfg_rdata[F_IE]                = ie;
    cfg_rdata[F_CLR]               = 1'b0;
    cfg_rdata[F_FLAG]              = flag;
  end

  assign irq = flag & ie;
endmodule

// File: rtl/rti_wdog_timer_chk.sv
module rti_wdog_timer_chk
  import rti_wdog_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [WR_W-1:0] cfg_wdata,
  input logic [RD_W-1:0] cfg_rdata,
  input logic            wd_enable,
  input logic            wd_clear,
  input logic            irq,
  input logic            wd_rst_req
);
  p_rate_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata[F_RATE_HI:F_RATE_LO] == $past(cfg_wdata[F_RATE_HI:F_RATE_LO]));

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[F_FLAG] && !(cfg_wr && cfg_wdata[F_CLR])) |=> cfg_rdata[F_FLAG]);

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_rdata[F_FLAG] && cfg_rdata[F_IE]));

  p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req);

  p_req_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> cfg_rdata[F_FLAG]);

  p_clear_blocks_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |=> !wd_rst_req);

  p_req_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> $past(wd_enable));
endmodule

bind rti_wdog_timer rti_wdog_timer_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .wd_enable  (wd_enable),
  .wd_clear   (wd_clear),
  .irq        (irq),
  .wd_rst_req (wd_rst_req)
);

// File: tb/rti_wdog_timer_tb_top.sv
module rti_wdog_timer_tb_top;
  localparam int BW = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [3:0] cfg_wdata;
  logic [4:0] cfg_rdata;
  logic       wd_enable;
  logic       wd_clear;
  logic       irq;
  logic       wd_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int e = 0;
  int req_count = 0;

  always #10 clk = ~clk;

  rti_wdog_timer #(.BASE_W(BW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .wd_enable  (wd_enable),
    .wd_clear   (wd_clear),
    .irq        (irq),
    .wd_rst_req (wd_rst_req)
  );

  function automatic int per(int sel);
    return 1 << (BW + sel);
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk);
    e++;
    if (wd_rst_req) req_count++;
  endtask

  task automatic run_to(int target);
    while (e < target) tick1();
  endtask

  task automatic wr(logic [3:0] d);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    tick1();
    cfg_wr = 1'b0;
  endtask

  task automatic wdclr();
    wd_clear = 1'b1;
    tick1();
    wd_clear = 1'b0;
  endtask

  task automatic do_reset(logic wden);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    cfg_wdata = '0;
    wd_clear = 1'b0;
    wd_enable = wden;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    e = 0;
    req_count = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // R1 reset values, R2 default rate wrap
  task automatic test_reset();
    do_reset(1'b0);
    chk("R1", "rdata after reset", int'(cfg_rdata), 5'b00011);
    chk("R1", "irq after reset", int'(irq), 0);
    chk("R1", "req after reset", int'(wd_rst_req), 0);
    run_to(per(3) - 1);
    chk("R2", "flag before default wrap", int'(cfg_rdata[4]), 0);
    run_to(per(3));
    chk("R2", "flag at default wrap", int'(cfg_rdata[4]), 1);
  endtask

  // R2 period for a chosen select
  task automatic test_period(int sel);
    int p;
    p = per(sel);
    do_reset(1'b0);
    wr(4'(sel));
    chk("R2", "rate readback", int'(cfg_rdata[1:0]), sel);
    run_to(p - 1);
    chk("R2", "flag before first wrap", int'(cfg_rdata[4]), 0);
    run_to(p);
    chk("R2", "flag at first wrap", int'(cfg_rdata[4]), 1);
    wr(4'(8 + sel));
    run_to(2 * p - 1);
    chk("R2", "flag before second wrap", int'(cfg_rdata[4]), 0);
    run_to(2 * p);
    chk("R2", "flag at second wrap", int'(cfg_rdata[4]), 1);
  endtask

  // R3 sticky flag, R4 clear bit reads 0, R5 irq gating
  task automatic test_flag_clear();
    do_reset(1'b0);
    run_to(per(3));
    chk("R5", "irq with enable off", int'(irq), 0);
    wr(4'b0111);
    chk("R3", "flag kept by write without clear", int'(cfg_rdata[4]), 1);
    chk("R4", "clear bit reads 0", int'(cfg_rdata[3]), 0);
    chk("R5", "irq with flag and enable", int'(irq), 1);
    run_to(per(3) + 40);
    chk("R3", "flag still held", int'(cfg_rdata[4]), 1);
    wr(4'b1111);
    chk("R3", "flag cleared by write", int'(cfg_rdata[4]), 0);
    chk("R4", "clear bit reads 0 after clear", int'(cfg_rdata[3]), 0);
    chk("R5", "irq with enable but no flag", int'(irq), 0);
  endtask

  // R6 clear write on the wrap edge
  task automatic test_collision();
    do_reset(1'b0);
    run_to(per(3) - 1);
    wr(4'b1011);
    chk("R6", "flag after clear on wrap edge", int'(cfg_rdata[4]), 1);
  endtask

  // R7 timeout, R11 divider restart
  task automatic test_wd_timeout();
    int p;
    p = per(0);
    do_reset(1'b1);
    wr(4'b0000);
    run_to(8 * p - 1);
    chk("R7", "req before timeout", int'(wd_rst_req), 0);
    run_to(8 * p);
    chk("R7", "req at timeout", int'(wd_rst_req), 1);
    chk("R7", "flag on timeout edge", int'(cfg_rdata[4]), 1);
    run_to(8 * p + 1);
    chk("R7", "req drops next cycle", int'(wd_rst_req), 0);
    chk("R7", "single request pulse", req_count, 1);
    wr(4'b1000);
    run_to(9 * p - 1);
    chk("R11", "flag before restarted wrap", int'(cfg_rdata[4]), 0);
    run_to(9 * p);
    chk("R11", "flag at restarted wrap", int'(cfg_rdata[4]), 1);
  endtask

  // R8 clear on and just after a wrap edge, and steady servicing
  task automatic test_wd_clear();
    int p;
    int t_clr;
    p = per(0);
    do_reset(1'b1);
    wr(4'b0000);
    run_to(p - 1);
    wdclr();
    t_clr = e;
    run_to(t_clr + 8 * p - 1);
    chk("R8", "no req before 8P after clear on wrap", int'(wd_rst_req), 0);
    run_to(t_clr + 8 * p);
    chk("R8", "req exactly 8P after clear on wrap", int'(wd_rst_req), 1);

    do_reset(1'b1);
    wr(4'b0000);
    run_to(p);
    wdclr();
    t_clr = e;
    run_to(t_clr + 8 * p - 2);
    chk("R8", "no req before 8P-1 after late clear", int'(wd_rst_req), 0);
    run_to(t_clr + 8 * p - 1);
    chk("R8", "req 8P-1 after late clear", int'(wd_rst_req), 1);
    chk("R8", "delay above 7P", int'((8 * p - 1) > 7 * p), 1);

    do_reset(1'b1);
    wr(4'b0000);
    for (int i = 0; i < 6; i++) begin
      run_to(e + 99);
      wdclr();
    end
    chk("R8", "serviced watchdog gives no req", req_count, 0);
  endtask

  // R9 disabled watchdog
  task automatic test_wd_disabled();
    do_reset(1'b0);
    wr(4'b0000);
    run_to(1200);
    chk("R9", "no req while disabled", req_count, 0);
  endtask

  // R10 timeout follows rate
  task automatic test_wd_rate();
    do_reset(1'b1);
    wr(4'b0001);
    run_to(8 * per(1) - 1);
    chk("R10", "no req before 8P at rate 1", int'(wd_rst_req), 0);
    run_to(8 * per(1));
    chk("R10", "req at 8P at rate 1", int'(wd_rst_req), 1);
    do_reset(1'b1);
    run_to(8 * per(3) - 1);
    chk("R10", "no req before 8P at rate 3", int'(wd_rst_req), 0);
    run_to(8 * per(3));
    chk("R10", "req at 8P at rate 3", int'(wd_rst_req), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    cfg_wdata = '0;
    wd_enable = 1'b0;
    wd_clear = 1'b0;
    test_reset();
    for (int s = 0; s < 4; s++) test_period(s);
    test_flag_clear();
    test_collision();
    test_wd_timeout();
    test_wd_clear();
    test_wd_disabled();
    test_wd_rate();
    summary();
    $finish;
  end
endmodule